// File: doc/BRIEF.md
# SPI Serial Clock Divider

This block derives the serial clock for an SPI shift engine from the system clock. Software loads one 32-bit setup word. The word selects a full-rate bypass, or a two-stage division made of a prescaler and an inner cycle counter. Two further fields place the rising and falling transitions inside each inner cycle, and so set the duty cycle. The shift engine holds `run` high for the length of a transfer. While `run` is low the divider stays parked and the serial clock stays low.

Alongside the serial clock, the block gives the engine a one-cycle marker for each rising edge, a one-cycle marker for each falling edge, and the prescaler tick. The shift engine applies clock polarity and phase on top of these signals. Choosing field values for a target frequency is left to software.

Top module: `spi_sclk_divider`

## Requirements
- R1: While `rst_n` is low, and on the first clock edge at which `run` is sampled low, `sclk`, `rise_pulse`, `fall_pulse` and `tick` all become 0. They stay 0 for as long as `run` stays low. No edge marker is given when a transfer is cut short with `sclk` high.
- R2: Each field holds its effective value minus one. The prescaler field sits in bits [30:18], so its effective value P runs from 1 to 8192. Counting the first clock edge with `run` high as edge 1, `tick` is 1 after edge k exactly when k is a multiple of P.
- R3: The cycle count field sits in bits [17:12], giving an effective N from 1 to 64. Tick positions number 1, 2, …, N and then start again at 1, so one serial clock period lasts P×N system cycles.
- R4: The high-point field sits in bits [11:6], giving an effective H. `sclk` becomes 1 on the tick whose position equals H.
- R5: The low-point field sits in bits [5:0], giving an effective L. `sclk` becomes 0 on the tick whose position equals L. When H equals L, the low transition wins and `sclk` stays low. When H is greater than L, the clock stays low until the first H position and from then on is high between H and L across the wrap.
- R6: `rise_pulse` is 1 for exactly the first cycle in which `sclk` shows a new 1. `fall_pulse` is 1 for exactly the first cycle in which `sclk` shows a new 0. The two are never 1 together, and each one only comes with `tick`.
- R7: When bit 31 is set, all other fields are ignored. The divider then makes the fastest clock it can register: every cycle is a tick, and `sclk` is 1 after odd edges and 0 after even edges.
- R8: The setup word is captured on every edge at which `run` is low. A change to `cfg_word` while `run` is high has no effect on the output until `run` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the clock tree |
| cfg_word | input | 32 | Setup word: bypass, prescaler, cycle count, high point and low point |
| run | input | 1 | High for the length of a transfer |
| sclk | output | 1 | Un-inverted serial clock |
| rise_pulse | output | 1 | One-cycle marker of a rising edge of `sclk` |
| fall_pulse | output | 1 | One-cycle marker of a falling edge of `sclk` |
| tick | output | 1 | Prescaler terminal-count marker |

## Verification
The hardest situation to reach is a change to the setup word in the middle of a transfer, because the output must not move at all. The stimulus therefore drives a completely different word partway through a running case and keeps checking against the old fields. It then drops `run` and starts a new case to confirm that the new word is taken only once the divider is idle. Two further corners need long or unusual runs: the full 8192 prescale, and high points that lie beyond or equal to the low point. Directed cases cover these, mixed in with seeded random field sets.

// File: rtl/spi_div_pkg.sv
package spi_div_pkg;
  // Default field geometry of the setup word
  localparam int unsigned SPD_FIELD_W = 6;
  localparam int unsigned SPD_PRE_W   = 13;

  typedef enum logic {
    SCLK_LOW  = 1'b0,
    SCLK_HIGH = 1'b1
  } sclk_lvl_e;
endpackage

// File: rtl/spi_div_cfg.sv
// Holds the setup word while a transfer runs and decodes its fields.
module spi_div_cfg #(
  parameter int unsigned FIELD_W = spi_div_pkg::SPD_FIELD_W,
  parameter int unsigned PRE_W   = spi_div_pkg::SPD_PRE_W,
  localparam int unsigned CFG_W  = 3 * FIELD_W + PRE_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [CFG_W-1:0]   cfg_word,
  output logic [PRE_W-1:0]   pre_lim,
  output logic [FIELD_W-1:0] n_lim,
  output logic [FIELD_W-1:0] hi_pt,
  output logic [FIELD_W-1:0] lo_pt
);
  localparam int unsigned LO_OFS  = 0;
  localparam int unsigned HI_OFS  = FIELD_W;
  localparam int unsigned N_OFS   = 2 * FIELD_W;
  localparam int unsigned PRE_OFS = 3 * FIELD_W;
  localparam int unsigned BYP_BIT = CFG_W - 1;

  logic [CFG_W-1:0] cfg_q;
  logic [CFG_W-1:0] cfg_d;
  logic             load_en;

  assign load_en = ~run;

  always_comb begin
    cfg_d = cfg_q;
    if (load_en) cfg_d = cfg_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  always_comb begin
    if (cfg_q[BYP_BIT]) begin
      pre_lim = '0;
      n_lim   = FIELD_W'(1);
      hi_pt   = '0;
      lo_pt   = FIELD_W'(1);
    end else begin
      pre_lim = cfg_q[PRE_OFS +: PRE_W];
      n_lim   = cfg_q[N_OFS   +: FIELD_W];
      hi_pt   = cfg_q[HI_OFS  +: FIELD_W];
      lo_pt   = cfg_q[LO_OFS  +: FIELD_W];
    end
  end
endmodule

// File: rtl/spi_div_prescale.sv
// First stage: counts system cycles up to the prescaler limit.
module spi_div_prescale #(
  parameter int unsigned PRE_W = spi_div_pkg::SPD_PRE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PRE_W-1:0] pre_lim,
  output logic             tick_now
);
  logic [PRE_W-1:0] pc_q;
  logic [PRE_W-1:0] pc_d;

  assign tick_now = run & (pc_q == pre_lim);

  always_comb begin
    pc_d = pc_q;
    if (!run)          pc_d = '0;
    else if (tick_now) pc_d = '0;
    else               pc_d = pc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end
endmodule

// File: rtl/spi_div_phase.sv
// Second stage: tick position counter and serial clock level with edge markers.
module spi_div_phase #(
  parameter int unsigned FIELD_W = spi_div_pkg::SPD_FIELD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               tick_now,
  input  logic [FIELD_W-1:0] n_lim,
  input  logic [FIELD_W-1:0] hi_pt,
  input  logic [FIELD_W-1:0] lo_pt,
  output logic               sclk,
  output logic               rise_pulse,
  output logic               fall_pulse,
  output logic               tick
);
  import spi_div_pkg::*;

  logic [FIELD_W-1:0] ic_q, ic_d;
  sclk_lvl_e          lvl_q, lvl_d;
  logic               rise_q, rise_d;
  logic               fall_q, fall_d;
  logic               tick_q, tick_d;
  logic               hit_hi, hit_lo;

  assign hit_hi = (ic_q == hi_pt);
  assign hit_lo = (ic_q == lo_pt);

  always_comb begin
    ic_d  = ic_q;
    lvl_d = lvl_q;
    if (!run) begin
      ic_d  = '0;
      lvl_d = SCLK_LOW;
    end else if (tick_now) begin
      ic_d = (ic_q == n_lim) ? '0 : ic_q + 1'b1;
      if (hit_lo)      lvl_d = SCLK_LOW;
      else if (hit_hi) lvl_d = SCLK_HIGH;
    end
    rise_d = run & (lvl_d == SCLK_HIGH) & (lvl_q == SCLK_LOW);
    fall_d = run & (lvl_d == SCLK_LOW)  & (lvl_q == SCLK_HIGH);
    tick_d = tick_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ic_q   <= '0;
      lvl_q  <= SCLK_LOW;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      ic_q   <= ic_d;
      lvl_q  <= lvl_d;
      rise_q <= rise_d;
      fall_q <= fall_d;
      tick_q <= tick_d;
    end
  end

  assign sclk       = (lvl_q == SCLK_HIGH);
  assign rise_pulse = rise_q;
  assign fall_pulse = fall_q;
  assign tick       = tick_q;
endmodule

// File: rtl/spi_sclk_divider.sv
module spi_sclk_divider #(
  parameter int unsigned FIELD_W = spi_div_pkg::SPD_FIELD_W,
  parameter int unsigned PRE_W   = spi_div_pkg::SPD_PRE_W,
  localparam int unsigned CFG_W  = 3 * FIELD_W + PRE_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             run,
  output logic             sclk,
  output logic             rise_pulse,
  output logic             fall_pulse,
  output logic             tick
);
  logic [PRE_W-1:0]   pre_lim;
  logic [FIELD_W-1:0] n_lim, hi_pt, lo_pt;
  logic               tick_now;

  spi_div_cfg #(.FIELD_W(FIELD_W), .PRE_W(PRE_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .run(run), .cfg_word(cfg_word),
    .pre_lim(pre_lim), .n_lim(n_lim), .hi_pt(hi_pt), .lo_pt(lo_pt)
  );

  spi_div_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .pre_lim(pre_lim), .tick_now(tick_now)
  );

  spi_div_phase #(.FIELD_W(FIELD_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .run(run), .tick_now(tick_now),
    .n_lim(n_lim), .hi_pt(hi_pt), .lo_pt(lo_pt),
    .sclk(sclk), .rise_pulse(rise_pulse), .fall_pulse(fall_pulse), .tick(tick)
  );
endmodule

// File: rtl/spi_div_chk.sv
module spi_div_chk #(
  parameter int unsigned CFG_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             sclk,
  input logic             rise_pulse,
  input logic             fall_pulse,
  input logic             tick,
  input logic [CFG_W-1:0] cfg_held
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!sclk && !rise_pulse && !fall_pulse && !tick));

  // R6
  no_dual_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_pulse && fall_pulse));

  // R6
  rise_marked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> rise_pulse);

  // R6
  rise_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_pulse |-> sclk);

  // R6
  fall_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_pulse |-> !sclk);

  // R6
  edge_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_pulse || fall_pulse) |-> tick);

  // R8
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> $stable(cfg_held));
endmodule

bind spi_sclk_divider spi_div_chk #(.CFG_W(CFG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .sclk(sclk),
  .rise_pulse(rise_pulse), .fall_pulse(fall_pulse), .tick(tick),
  .cfg_held(u_cfg.cfg_q)
);

// File: tb/test_spi_sclk_divider.sv
module test_spi_sclk_divider;
  logic        clk;
  logic        rst_n;
  logic [31:0] cfg_word;
  logic        run;
  logic        sclk, rise_pulse, fall_pulse, tick;
  int          errs;
  int          checks;
  bit          done;

  spi_sclk_divider i_spi_sclk_divider (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .run(run),
    .sclk(sclk), .rise_pulse(rise_pulse), .fall_pulse(fall_pulse), .tick(tick)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [31:0] mk(bit byp, int p, int n, int h, int l);
    return {byp, 13'(p - 1), 6'(n - 1), 6'(h - 1), 6'(l - 1)};
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h (sclk,rise,fall,tick)", req, act, expv);
    end
  endtask

  task automatic check_idle(string req);
    @(negedge clk);
    chk({sclk, rise_pulse, fall_pulse, tick} == 4'b0000, req,
        int'({sclk, rise_pulse, fall_pulse, tick}), 0);
  endtask

  // One transfer: load cfg while idle, run for 'cycles' edges and compare
  // against values derived from the effective fields. Optionally swap the
  // setup word after edge change_at (it must be ignored).
  task automatic run_case(logic [31:0] cfg, int cycles, string req,
                          logic [31:0] alt, int change_at);
    int p, n, h, l, m, q;
    bit s, s_prev, tk;
    logic [3:0] expv, act;
    if (cfg[31]) begin
      p = 1; n = 2; h = 1; l = 2;
    end else begin
      p = int'(cfg[30:18]) + 1;
      n = int'(cfg[17:12]) + 1;
      h = int'(cfg[11:6]) + 1;
      l = int'(cfg[5:0]) + 1;
    end
    @(negedge clk);
    cfg_word = cfg;
    run      = 1'b0;
    @(negedge clk);
    run = 1'b1;
    s = 1'b0; s_prev = 1'b0; m = 0;
    for (int k = 1; k <= cycles; k++) begin
      @(negedge clk);
      tk = ((k % p) == 0);
      if (tk) begin
        m++;
        q = ((m - 1) % n) + 1;
        if (q == h) s = 1'b1;
        if (q == l) s = 1'b0;
      end
      expv = {s, s & ~s_prev, ~s & s_prev, tk};
      act  = {sclk, rise_pulse, fall_pulse, tick};
      chk(act == expv, req, int'(act), int'(expv));
      s_prev = s;
      if (k == change_at) cfg_word = alt;
    end
    run = 1'b0;
    check_idle("R1");
    check_idle("R1");
  endtask

  initial begin
    errs = 0; checks = 0; done = 1'b0;
    #(200000 * 8);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n    = 1'b0;
    run      = 1'b1;
    cfg_word = mk(1'b1, 1, 2, 1, 2);
    // R1: reset state
    check_idle("R1");
    check_idle("R1");
    @(negedge clk);
    rst_n = 1'b1;
    run   = 1'b0;
    check_idle("R1");

    // R3 R4: plain 50% duty, small prescaler
    run_case(mk(1'b0, 1, 4, 2, 4), 20, "R3", 32'd0, 0);
    run_case(mk(1'b0, 3, 4, 2, 4), 40, "R2", 32'd0, 0);
    // R5: low point below cycle count
    run_case(mk(1'b0, 1, 8, 2, 5), 30, "R5", 32'd0, 0);
    // R5: high point after low point, high across the wrap
    run_case(mk(1'b0, 2, 6, 4, 2), 40, "R5", 32'd0, 0);
    // R5: equal points keep the clock low
    run_case(mk(1'b0, 1, 4, 2, 2), 16, "R5", 32'd0, 0);
    // R4: high point beyond n never rises
    run_case(mk(1'b0, 1, 3, 10, 3), 12, "R4", 32'd0, 0);
    // R3: widest inner count
    run_case(mk(1'b0, 1, 64, 32, 64), 140, "R3", 32'd0, 0);
    // R2: widest prescaler
    run_case(mk(1'b0, 8192, 2, 1, 2), 2 * 8192 * 2 + 3, "R2", 32'd0, 0);
    // R7: bypass ignores every other field
    run_case(32'h8000_0000 | ($urandom & 32'h7FFF_FFFF), 12, "R7", 32'd0, 0);
    run_case(32'hFFFF_FFFF, 12, "R7", 32'd0, 0);
    // R8: change during a transfer is ignored, then taken after idle
    run_case(mk(1'b0, 2, 4, 2, 4), 40, "R8", mk(1'b1, 1, 2, 1, 2), 7);
    run_case(mk(1'b0, 2, 4, 2, 4), 40, "R8", mk(1'b0, 1, 6, 3, 6), 9);
    run_case(mk(1'b0, 1, 6, 3, 6), 24, "R8", 32'd0, 0);
    // R6 R3 R4: seeded random field sets
    for (int i = 0; i < 25; i++) begin
      int rp, rn, rh;
      rp = 1 + int'($urandom % 4);
      rn = 2 + int'($urandom % 7);
      rh = 1 + int'($urandom % (rn - 1));
      run_case(mk(1'b0, rp, rn, rh, rn), 3 * rp * rn + 3, "R6", 32'd0, 0);
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule